// File: doc/BRIEF.md
# Mixed-Width Programmable FIR Equaliser

This block is a 96-tap finite impulse response filter placed directly after a pair of converters, ahead of any rate change, and working on real samples. It equalises one channel's gain, flattens its amplitude response across the band, and trims its phase against a reference channel. Two lanes share one instance. They run either as two independent real filters or, with the pairing pin set, as the I and Q halves of one complex stream that both go through the same coefficient set.

Coefficient storage is not uniform. A short run of centre taps keeps 16 bits, the taps on both sides of that run keep 12 bits, and every other tap keeps 6 bits. Narrow coefficients sit at the top of the 16-bit coefficient word, and the bits below them read as zero. There are two complete banks. A write always lands in the bank that is not in use, and a select pin swaps banks at the next accepted sample. Software can therefore load a new response in the background and switch to it without a glitch. A bypass pin turns the filter into a plain delay whose length matches the filter's group delay.

Top module: `mixw_fir`

## Requirements
- R1: While reset is low, and after it is released, out_vld, out_a and out_b are zero, every stored coefficient is zero and bank 0 is the active bank.
- R2: Each lane computes y[n] = sum over k=0..95 of c[k]*x[n-k], where x[0] is the newest accepted sample, x[n-k] is zero before the first sample, and c[k] is a signed Q1.15 coefficient. Lane a reads lane a's coefficients and lane b reads lane b's coefficients.
- R3: A sample accepted on a rising edge with in_vld high produces its result on the second rising edge after it, and out_vld is high for exactly that one cycle. Between results, out_a and out_b hold their values.
- R4: Taps 40 to 55 store all 16 bits of wr_data. Taps 32 to 39 and 56 to 63 store only bits 15:4. All other taps store only bits 15:10. The bits that are not stored act as zero in the coefficient.
- R5: A write with wr_en high goes to tap wr_addr of lane wr_lane (0 = a, 1 = b) in the bank that is not active. A write with wr_addr of 96 or more changes nothing. A write never changes the output computed from the active bank.
- R6: The active bank takes the value of bank_sel only on an edge where in_vld is high. Every result uses coefficients from a single bank.
- R7: With bypass high, each lane outputs x[n-47], its input delayed by 47 samples.
- R8: The full sum is rounded by adding 2^14 and shifting right arithmetically by 15. The result is then saturated to the range -32768 to 32767.
- R9: With pair_mode high, lane b uses lane a's coefficients, and lane b's own stored coefficients stay unchanged for later use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Sample strobe for both lanes |
| in_a | input | 16 | Lane a sample, signed |
| in_b | input | 16 | Lane b sample, signed |
| bank_sel | input | 1 | Requested active bank, taken with the next sample |
| bypass | input | 1 | Output is the delayed input instead of the filter result |
| pair_mode | input | 1 | Lane b shares lane a's coefficients |
| wr_en | input | 1 | Coefficient write strobe |
| wr_lane | input | 1 | Lane that the write addresses |
| wr_addr | input | 7 | Tap index of the write |
| wr_data | input | 16 | Coefficient value, Q1.15 |
| out_vld | output | 1 | Result strobe |
| out_a | output | 16 | Lane a result, signed |
| out_b | output | 16 | Lane b result, signed |

## Verification
If the active-bank latch holds the wrong value, the very next result jumps to the other bank's response. A write that lands in the active bank changes the output two edges after the next sample. A coefficient stored at the wrong width or position only shows up once a nonzero sample has reached that tap, which takes up to 95 samples. The bench therefore sends impulses and long random runs so that every tap is reached. A fault in the delay line shows up in bypass mode after 47 samples, and a rounding fault shows up on the first sum that falls on a half step.

// File: rtl/mixw_fir.sv
module mixw_fir #(
  parameter int NTAPS  = 96,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int W16_LO = 40,
  parameter int W16_HI = 55,
  parameter int W12_LO = 32,
  parameter int W12_HI = 63,
  parameter int MIDW   = 12,
  parameter int NARW   = 6,
  parameter int AW     = $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_a,
  input  logic signed [DW-1:0] in_b,
  input  logic                 bank_sel,
  input  logic                 bypass,
  input  logic                 pair_mode,
  input  logic                 wr_en,
  input  logic                 wr_lane,
  input  logic [AW-1:0]        wr_addr,
  input  logic [CW-1:0]        wr_data,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);

  localparam int LANES = 2;
  localparam int FRAC  = CW - 1;
  localparam int ACCW  = DW + CW + $clog2(NTAPS) + 1;
  localparam int BYP   = NTAPS / 2 - 1;
  localparam logic signed [ACCW-1:0] PMAX = (ACCW'(1) <<< (DW - 1)) - ACCW'(1);
  localparam logic signed [ACCW-1:0] NMIN = -(ACCW'(1) <<< (DW - 1));
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (FRAC - 1);

  function automatic int tap_w(int t);
    if (t >= W16_LO && t <= W16_HI) return CW;
    if (t >= W12_LO && t <= W12_HI) return MIDW;
    return NARW;
  endfunction

  logic                        act_bank;
  logic                        vld_q;
  logic signed [DW-1:0]        dl [LANES][NTAPS];
  logic [LANES*2*NTAPS*CW-1:0] cf;
  logic signed [ACCW-1:0]      acc [LANES];
  logic signed [DW-1:0]        res [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_bank <= 1'b0;
      vld_q    <= 1'b0;
      for (int l = 0; l < LANES; l++)
        for (int t = 0; t < NTAPS; t++)
          dl[l][t] <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        act_bank <= bank_sel;
        dl[0][0] <= in_a;
        dl[1][0] <= in_b;
        for (int l = 0; l < LANES; l++)
          for (int t = 1; t < NTAPS; t++)
            dl[l][t] <= dl[l][t-1];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar b = 0; b < 2; b++) begin : g_bank
      for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        localparam int TW = tap_w(t);
        logic signed [TW-1:0] st;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            st <= '0;
          else if (wr_en && wr_lane == 1'(l) && wr_addr == AW'(t) && act_bank != 1'(b))
            st <= wr_data[CW-1 -: TW];
        end
        assign cf[((l*2 + b)*NTAPS + t)*CW +: CW] = CW'(st) <<< (CW - TW);
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      acc[l] = '0;
      for (int t = 0; t < NTAPS; t++)
        acc[l] = acc[l] + ACCW'(dl[l][t]) *
                 ACCW'($signed(cf[(((pair_mode ? 0 : l)*2 + int'(act_bank))*NTAPS + t)*CW +: CW]));
      acc[l] = (acc[l] + HALF) >>> FRAC;
      if (acc[l] > PMAX)      res[l] = PMAX[DW-1:0];
      else if (acc[l] < NMIN) res[l] = NMIN[DW-1:0];
      else                    res[l] = acc[l][DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_a   <= '0;
      out_b   <= '0;
    end else begin
      out_vld <= vld_q;
      if (vld_q) begin
        out_a <= bypass ? dl[0][BYP] : res[0];
        out_b <= bypass ? dl[1][BYP] : res[1];
      end
    end
  end

  // R3
  lat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ##1 out_vld);

  // R3
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ##1 !out_vld);

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |=> ($stable(out_a) && $stable(out_b)));

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(act_bank));

  // R6
  bank_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (act_bank == $past(bank_sel)));

endmodule

// File: tb/mixw_fir_tb.sv
module mixw_fir_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic signed [15:0] in_a = '0;
  logic signed [15:0] in_b = '0;
  logic bank_sel = 1'b0, bypass = 1'b0, pair_mode = 1'b0;
  logic wr_en = 1'b0, wr_lane = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic out_vld;
  logic signed [15:0] out_a, out_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixw_fir u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .bank_sel(bank_sel), .bypass(bypass), .pair_mode(pair_mode),
    .wr_en(wr_en), .wr_lane(wr_lane), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_vld(out_vld), .out_a(out_a), .out_b(out_b));

  int nchk = 0, nerr = 0, cyc = 0;
  string req = "R1";
  int hist [2][96];
  int cm [2][2][96];
  int mact = 0;
  bit ms1 = 0, ev = 0;
  int ea = 0, eb = 0;
  bit [31:0] seed = 32'h1234_5678;

  function automatic int keep_bits(int t, logic [15:0] d);
    logic [15:0] v = d;
    if (t >= 40 && t <= 55) v = d;
    else if (t >= 32 && t <= 63) v[3:0] = '0;
    else v[9:0] = '0;
    return int'($signed(v));
  endfunction

  function automatic int model_out(int l);
    longint s = 0;
    int cl;
    if (bypass) return hist[l][47];
    cl = pair_mode ? 0 : l;
    for (int t = 0; t < 96; t++) s += longint'(hist[l][t]) * longint'(cm[cl][mact][t]);
    s = (s + 16384) >>> 15;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return int'(s);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) for (int t = 0; t < 96; t++) begin
        hist[l][t] = 0; cm[l][0][t] = 0; cm[l][1][t] = 0;
      end
      mact = 0; ms1 = 0; ev = 0; ea = 0; eb = 0;
    end else begin
      if (ms1) begin ea = model_out(0); eb = model_out(1); end
      ev = ms1;
      if (wr_en && wr_addr < 96)
        cm[wr_lane][1-mact][wr_addr] = keep_bits(int'(wr_addr), wr_data);
      if (in_vld) begin
        for (int l = 0; l < 2; l++) for (int t = 95; t > 0; t--) hist[l][t] = hist[l][t-1];
        hist[0][0] = int'(in_a); hist[1][0] = int'(in_b);
        mact = int'(bank_sel);
      end
      ms1 = in_vld;
    end
  end

  task automatic check(string r, int act, int exp, string what);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", r, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3", int'(out_vld), int'(ev), "out_vld");
      check(req, int'(out_a), ea, "out_a");
      check(req, int'(out_b), eb, "out_b");
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  task automatic send(int a, int b, bit bs);
    in_vld = 1'b1; in_a = 16'(a); in_b = 16'(b); bank_sel = bs;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic wr(bit lane, int addr, int data);
    wr_en = 1'b1; wr_lane = lane; wr_addr = 7'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R1: reset state
    check("R1", int'(out_vld), 0, "out_vld in reset");
    check("R1", int'(out_a), 0, "out_a in reset");
    check("R1", int'(out_b), 0, "out_b in reset");
    rst_n = 1'b1;
    idle(2);

    // R7: bypass delays by 47 samples
    req = "R7"; bypass = 1'b1;
    for (int k = 0; k < 110; k++) send(rnd16(), k * 97 - 5000, 1'b0);
    idle(3); bypass = 1'b0;

    // R5: writes to inactive bank 1, including out-of-range addresses
    req = "R5";
    wr(0, 0, 16'h7FFF); wr(0, 35, 16'h1234); wr(0, 45, 16'h8001);
    wr(0, 60, 16'hF00F); wr(0, 95, 16'h5A5A); wr(0, 50, 16'h2000);
    wr(1, 2, 16'h4000); wr(1, 50, 16'hC000); wr(1, 33, 16'h0F0F);
    wr(0, 100, 16'h7FFF); wr(1, 127, 16'h7FFF);
    for (int k = 0; k < 60; k++) send(rnd16(), rnd16(), 1'b0);
    idle(3);

    // R4: impulse on bank 1 reveals stored width per tap
    req = "R4";
    send(32767, 0, 1'b1);
    for (int k = 0; k < 100; k++) send(0, 0, 1'b1);
    send(-32768, -32768, 1'b1);
    for (int k = 0; k < 100; k++) send(0, 0, 1'b1);
    idle(3);

    // R2: independent lanes on random data
    req = "R2";
    for (int k = 0; k < 150; k++) send(rnd16(), rnd16(), 1'b1);
    idle(3);

    // R8: rounding half steps on lane b (tap 2 = 0.5)
    req = "R8";
    for (int k = 0; k < 96; k++) send(0, 0, 1'b1);
    send(0, 3, 1'b1); send(0, -3, 1'b1); send(0, 1, 1'b1); send(0, -1, 1'b1);
    for (int k = 0; k < 5; k++) send(0, 0, 1'b1);
    // R8: saturation using bank 0 filled with extremes
    for (int t = 0; t < 96; t++) wr(0, t, 16'h7FFF);
    for (int t = 0; t < 96; t++) wr(1, t, 16'h8000);
    for (int k = 0; k < 100; k++) send(32767, 32767, 1'b0);
    for (int k = 0; k < 100; k++) send(-32768, -32768, 1'b0);
    idle(3);

    // R9: pairing uses lane a coefficients on lane b, then lane b restores
    req = "R9"; pair_mode = 1'b1;
    for (int k = 0; k < 100; k++) send(rnd16(), rnd16(), 1'b1);
    idle(3); pair_mode = 1'b0;
    for (int k = 0; k < 100; k++) send(rnd16(), rnd16(), 1'b1);
    idle(3);

    // R6: bank toggled on back-to-back samples
    req = "R6";
    for (int k = 0; k < 100; k++) send(rnd16(), rnd16(), k[0]);
    bank_sel = 1'b0;
    idle(4);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule